// File: doc/BRIEF.md
# Processor Status Flags Register with Privilege-Masked Restore

This block holds the 32-bit status-flags word of a processor core. Arithmetic units update selected flag bits through a masked write port. A save port sends out the flag image for a stack push, in a 16-bit or a 32-bit form. A restore port takes a popped value, also in a 16-bit or a 32-bit form, and writes it back into the register.

The save path always shows the complete stored image, system-control flags included. The restore path filters its write. Reserved bits are hard-wired to their fixed values and never take the popped data. When the core runs at a privilege level other than the most privileged one, the interrupt-enable flag, the I/O privilege field, the resume flag and the virtual-mode flag keep their old values whatever the popped word holds. A 16-bit restore touches only the low half of the register.

Flag positions: carry 0, parity 2, auxiliary carry 4, zero 6, sign 7, trap 8, interrupt enable 9, direction 10, overflow 11, I/O privilege 13:12, nested task 14, resume 16, virtual mode 17.

Top module: `status_word_reg`

## Requirements
- R1: After the synchronous active-low reset, the stored word is 32'h0000_0002.
- R2: Bit 1 always reads as 1. Bits 3, 5, 15 and 31:18 always read as 0, on the state output and on the save output, whatever is popped or written.
- R3: With save_wide=1, save_data equals the full stored word, system flags included. With save_wide=0, save_data[15:0] equals the stored word's bits 15:0 and save_data[31:16] is 0.
- R4: A 32-bit restore (rest_wide=1) at privilege 0 writes every non-reserved bit from rest_data in the next cycle.
- R5: A 16-bit restore (rest_wide=0) writes only the non-reserved bits within 15:0, and bits 31:16 keep their values.
- R6: A restore with cur_priv not equal to 0 leaves bits 9, 13:12, 16 and 17 unchanged, and still writes the other non-reserved bits that its width covers.
- R7: With no restore, an ALU update (alu_we=1) writes the non-reserved bits selected by alu_mask from alu_flags, and leaves every other bit unchanged.
- R8: When a restore and an ALU update happen in the same cycle, only the restore takes effect.
- R9: With neither rest_en nor alu_we asserted, the stored word holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rest_en | input | 1 | Restore (pop-write) request |
| rest_wide | input | 1 | 1 = 32-bit restore, 0 = 16-bit restore |
| rest_data | input | 32 | Popped flag image |
| cur_priv | input | 2 | Current privilege level, 0 = most privileged |
| alu_we | input | 1 | ALU flag update enable |
| alu_mask | input | 32 | Bits the ALU update writes |
| alu_flags | input | 32 | New flag values from the ALU |
| save_wide | input | 1 | 1 = 32-bit save image, 0 = 16-bit |
| save_data | output | 32 | Flag image for a push |
| flags_q | output | 32 | Current stored flag word |

## Verification
The bench builds the block with its default parameters: a 32-bit word, a 16-bit narrow form and a 2-bit privilege level. With these values every privilege code is reachable, so both the unrestricted case at level 0 and the restricted case at levels 1 to 3 are driven. Both restore widths are driven as well. A behavioural model compares the state and the save image after every clock. The stimulus covers restores of all-ones and all-zeros images, restores that coincide with ALU updates, and a long stretch of random mixed traffic.

// File: rtl/status_word_pkg.sv
// Shared constants for the status-flags register: the field positions and
// the masks derived from them. Assumes the 32-bit flag layout listed in the brief.
package status_word_pkg;
    localparam int FLAG_W = 32;
    localparam int HALF_W = 16;
    localparam int PRIV_W = 2;

    localparam int B_CARRY = 0;
    localparam int B_ONE   = 1;
    localparam int B_PAR   = 2;
    localparam int B_AUX   = 4;
    localparam int B_ZERO  = 6;
    localparam int B_SIGN  = 7;
    localparam int B_TRAP  = 8;
    localparam int B_IEN   = 9;
    localparam int B_DIR   = 10;
    localparam int B_OVF   = 11;
    localparam int B_IOP0  = 12;
    localparam int B_IOP1  = 13;
    localparam int B_NEST  = 14;
    localparam int B_RES   = 16;
    localparam int B_VIRT  = 17;

    localparam logic [FLAG_W-1:0] ONE = {{(FLAG_W-1){1'b0}}, 1'b1};

    // Bits that hold state.
    localparam logic [FLAG_W-1:0] LIVE_MASK =
        (ONE << B_CARRY) | (ONE << B_PAR)  | (ONE << B_AUX)  | (ONE << B_ZERO) |
        (ONE << B_SIGN)  | (ONE << B_TRAP) | (ONE << B_IEN)  | (ONE << B_DIR)  |
        (ONE << B_OVF)   | (ONE << B_IOP0) | (ONE << B_IOP1) | (ONE << B_NEST) |
        (ONE << B_RES)   | (ONE << B_VIRT);

    // System-control bits that only privilege 0 may restore.
    localparam logic [FLAG_W-1:0] SYS_MASK =
        (ONE << B_IEN) | (ONE << B_IOP0) | (ONE << B_IOP1) |
        (ONE << B_RES) | (ONE << B_VIRT);

    // Reserved bits that are tied to 1.
    localparam logic [FLAG_W-1:0] FIXED_ONES = (ONE << B_ONE);

    // Reset image of the register.
    localparam logic [FLAG_W-1:0] RESET_WORD = FIXED_ONES;
endpackage

// File: rtl/sw_fixed_bits.sv
// Forces reserved positions of a flag image to their fixed values.
// Assumes LIVE_MASK and FIXED_ONES do not overlap.
module sw_fixed_bits
    import status_word_pkg::*;
#(
    parameter int W = FLAG_W
) (
    input  logic [W-1:0] raw,
    output logic [W-1:0] shaped
);
    // Keep the live bits and insert the tied values everywhere else.
    always_comb begin
        shaped = (raw & LIVE_MASK[W-1:0]) | FIXED_ONES[W-1:0];
    end
endmodule

// File: rtl/sw_pop_mask.sv
// Builds the per-bit write enable of a restore from its width and the
// current privilege. Assumes privilege 0 is the only unrestricted level.
module sw_pop_mask
    import status_word_pkg::*;
#(
    parameter int W  = FLAG_W,
    parameter int HW = HALF_W,
    parameter int PW = PRIV_W
) (
    input  logic          wide,
    input  logic [PW-1:0] priv,
    output logic [W-1:0]  mask
);
    localparam logic [W-1:0] NARROW_SPAN = {{(W-HW){1'b0}}, {HW{1'b1}}};

    logic [W-1:0] span;
    logic [W-1:0] guard;

    // Select which half or halves the restore covers.
    always_comb begin
        span = wide ? {W{1'b1}} : NARROW_SPAN;
    end

    // Shield the system-control bits below the top privilege.
    always_comb begin
        guard = (priv == '0) ? {W{1'b1}} : ~SYS_MASK[W-1:0];
    end

    // Combine the width span, the privilege guard and the live-bit set.
    always_comb begin
        mask = span & guard & LIVE_MASK[W-1:0];
    end
endmodule

// File: rtl/sw_store.sv
// Per-bit storage of the flag word. Live positions get a flop with a bit
// write enable. Reserved positions are tied off, so they cannot drift.
module sw_store
    import status_word_pkg::*;
#(
    parameter int W = FLAG_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] we,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        if (LIVE_MASK[i]) begin : g_live
            logic bit_r;
            // Load the new value when enabled, reset to the reset image.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    bit_r <= RESET_WORD[i];
                else if (we[i])
                    bit_r <= d[i];
            end
            assign q[i] = bit_r;
        end else begin : g_tied
            logic unused_in;
            assign unused_in = we[i] ^ d[i];
            assign q[i] = FIXED_ONES[i];
        end
    end
endmodule

// File: rtl/status_word_reg.sv
// Status-flags register with a save (push-read) port and a privilege-masked
// restore (pop-write) port. A restore overrides an ALU update in the same cycle.
module status_word_reg
    import status_word_pkg::*;
#(
    parameter int W  = FLAG_W,
    parameter int HW = HALF_W,
    parameter int PW = PRIV_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rest_en,
    input  logic          rest_wide,
    input  logic [W-1:0]  rest_data,
    input  logic [PW-1:0] cur_priv,
    input  logic          alu_we,
    input  logic [W-1:0]  alu_mask,
    input  logic [W-1:0]  alu_flags,
    input  logic          save_wide,
    output logic [W-1:0]  save_data,
    output logic [W-1:0]  flags_q
);
    localparam logic [W-1:0] LOW_HALF = {{(W-HW){1'b0}}, {HW{1'b1}}};

    logic [W-1:0] rest_mask;
    logic [W-1:0] wr_en;
    logic [W-1:0] wr_data;
    logic [W-1:0] image;

    sw_pop_mask #(.W(W), .HW(HW), .PW(PW)) u_mask (
        .wide (rest_wide),
        .priv (cur_priv),
        .mask (rest_mask)
    );

    // Pick the writer: a restore first, then an ALU update.
    always_comb begin
        if (rest_en) begin
            wr_en   = rest_mask;
            wr_data = rest_data;
        end else if (alu_we) begin
            wr_en   = alu_mask & LIVE_MASK[W-1:0];
            wr_data = alu_flags;
        end else begin
            wr_en   = '0;
            wr_data = alu_flags;
        end
    end

    sw_store #(.W(W)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_en),
        .d     (wr_data),
        .q     (flags_q)
    );

    sw_fixed_bits #(.W(W)) u_fix (
        .raw    (flags_q),
        .shaped (image)
    );

    // Trim the save image to the requested width.
    always_comb begin
        save_data = save_wide ? image : (image & LOW_HALF);
    end
endmodule

// File: rtl/sw_checker.sv
// Assertion checker for status_word_reg, attached through bind.
module sw_checker
    import status_word_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              rest_en,
    input logic              rest_wide,
    input logic [FLAG_W-1:0] rest_data,
    input logic [PRIV_W-1:0] cur_priv,
    input logic              alu_we,
    input logic              save_wide,
    input logic [FLAG_W-1:0] save_data,
    input logic [FLAG_W-1:0] flags_q
);
    AST_RESERVED_TIED: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_q & ~LIVE_MASK) == FIXED_ONES); // R2

    AST_NARROW_SAVE_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !save_wide |-> save_data[FLAG_W-1:HALF_W] == '0); // R3

    AST_WIDE_SAVE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        save_wide |-> save_data == flags_q); // R3

    AST_NARROW_REST_KEEPS_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        (rest_en && !rest_wide) |=> flags_q[FLAG_W-1:HALF_W] == $past(flags_q[FLAG_W-1:HALF_W])); // R5

    AST_USER_REST_KEEPS_SYS: assert property (@(posedge clk) disable iff (!rst_n)
        (rest_en && cur_priv != '0) |=> (flags_q & SYS_MASK) == $past(flags_q & SYS_MASK)); // R6

    AST_TOP_WIDE_REST_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (rest_en && rest_wide && cur_priv == '0) |=>
        flags_q == (($past(rest_data) & LIVE_MASK) | FIXED_ONES)); // R4

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!rest_en && !alu_we) |=> $stable(flags_q)); // R9
endmodule

bind status_word_reg sw_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rest_en   (rest_en),
    .rest_wide (rest_wide),
    .rest_data (rest_data),
    .cur_priv  (cur_priv),
    .alu_we    (alu_we),
    .save_wide (save_wide),
    .save_data (save_data),
    .flags_q   (flags_q)
);

// File: tb/status_word_reg_tb.sv
module status_word_reg_tb;
    localparam logic [31:0] LIVE = 32'h0003_7FD5;
    localparam logic [31:0] SYS  = 32'h0003_3200;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rest_en = 1'b0, rest_wide = 1'b0, alu_we = 1'b0, save_wide = 1'b0;
    logic [31:0] rest_data = '0, alu_mask = '0, alu_flags = '0;
    logic [1:0]  cur_priv = '0;
    logic [31:0] save_data, flags_q;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    logic [31:0] model = 32'h0000_0002;

    always #10 clk = ~clk;

    status_word_reg u_dut (
        .clk(clk), .rst_n(rst_n), .rest_en(rest_en), .rest_wide(rest_wide),
        .rest_data(rest_data), .cur_priv(cur_priv), .alu_we(alu_we),
        .alu_mask(alu_mask), .alu_flags(alu_flags), .save_wide(save_wide),
        .save_data(save_data), .flags_q(flags_q)
    );

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected < 100000", cycles);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
        end
    endtask

    // One clock: drive at a falling edge, update the model, compare at the next falling edge.
    task automatic step(input string tag, input bit pe, input bit pw, input logic [31:0] pd,
                        input logic [1:0] pr, input bit ae, input logic [31:0] am,
                        input logic [31:0] af, input bit sw);
        logic [31:0] m;
        logic [31:0] src;
        rest_en = pe; rest_wide = pw; rest_data = pd; cur_priv = pr;
        alu_we = ae; alu_mask = am; alu_flags = af; save_wide = sw;
        m = '0; src = af;
        if (pe) begin
            m = LIVE & (pw ? 32'hFFFF_FFFF : 32'h0000_FFFF);
            if (pr != 2'd0) m = m & ~SYS;
            src = pd;
        end else if (ae) begin
            m = am & LIVE;
        end
        model = (model & ~m) | (src & m);
        @(posedge clk);
        @(negedge clk);
        check({tag, " state"}, flags_q, model);
        check({tag, " save"}, save_data, sw ? model : (model & 32'h0000_FFFF));
    endtask

    initial begin
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset", flags_q, 32'h0000_0002);
        save_wide = 1'b1;
        #1 check("R3 wide save after reset", save_data, 32'h0000_0002);

        step("R4 top wide restore ones", 1, 1, 32'hFFFF_FFFF, 2'd0, 0, '0, '0, 1);
        check("R2 reserved after ones", flags_q & ~LIVE, 32'h0000_0002);
        step("R3 narrow save", 0, 0, '0, 2'd0, 0, '0, '0, 0);
        step("R6 user wide restore zeros", 1, 1, 32'h0000_0000, 2'd3, 0, '0, '0, 1);
        check("R6 sys kept", flags_q & SYS, SYS);
        step("R5 narrow top restore zeros", 1, 0, 32'h0000_0000, 2'd0, 0, '0, '0, 1);
        check("R5 upper kept", flags_q & 32'hFFFF_0000, 32'h0003_0000);
        step("R2 top restore zeros", 1, 1, 32'h0000_0000, 2'd0, 0, '0, '0, 1);
        step("R7 alu update", 0, 0, '0, 2'd0, 1, 32'h0000_08D5, 32'hFFFF_FFFF, 1);
        step("R8 restore beats alu", 1, 1, 32'h0000_0001, 2'd0, 1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1);
        step("R9 idle hold", 0, 0, 32'hFFFF_FFFF, 2'd0, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1);
        step("R6 user narrow restore ones", 1, 0, 32'hFFFF_FFFF, 2'd1, 0, '0, '0, 0);
        check("R6 if bit kept 0", flags_q & 32'h0000_3200, 32'h0000_0000);

        for (int i = 0; i < 400; i++) begin
            step("R8 random mix", 1'($urandom), 1'($urandom), $urandom, 2'($urandom),
                 1'($urandom), $urandom, $urandom, 1'($urandom));
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule